// File: doc/BRIEF.md
# Device Wake and Access Handshake

This block is the power-control corner of a host-visible register file. The host brings the device core to full power by setting an enable bit, and keeps it awake by holding a separate request bit. The block answers through status bits: a ready flag that rises once the modelled clock tree has settled, and a warning flag that announces an upcoming power-down. Internal resources may be touched only while ready is 1 and the warning is 0. The core itself may ask to sleep. The block lets it do so only when no host request is pending, and it runs a fixed warning window before the ready flag drops.

The same register file holds a three-bit power-save code, the synchronized level of an external radio-kill switch, an interrupt cause bit raised on every change of that switch, a self-clearing soft-reset strobe, and a bus-master stop request with its acknowledge. The clock tree, the PLL and link power management are not modelled. A parameterized wake delay stands in for them.

Registers are word-indexed by `reg_addr`: 0 is the power-control word, 1 is the reset-control word, 2 is the cause word and 3 is unmapped. Reads are combinational. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `wake_access_ctl`

## Requirements
- R1: After reset, word 0 reads 0 (with the kill pin low and no sleep request). Word 0 bit 0 (ready) stays 0 while bit 2 (enable) is 0, whatever bit 3 (request) holds.
- R2: Word 0 is written with bit 2 = 1 while bit 3 = 1 or the core sleep request is low. Bit 0 then reads 0 after WAKE_CYC edges and 1 after WAKE_CYC+1 edges, counted from the write edge.
- R3: `access_ok` is 1 exactly when word 0 bit 0 is 1 and bit 4 (going to sleep) is 0.
- R4: While ready, with the sleep request high and bit 3 clear, bit 4 rises one edge after the condition is first seen. It holds for SLEEP_CYC cycles with bit 0 still 1, and then bits 0 and 4 both fall on the same edge.
- R5: While bit 3 is 1 no sleep entry starts. Setting bit 3 while the core is powered down wakes it with the R2 timing.
- R6: Clearing bit 2 makes bit 0 and bit 4 read 0 one edge after the write edge.
- R7: Word 0 bits 26:24 give the power-save code. 3 (error) means enable is 0 while the sleep request is high. Otherwise 1 means enable is 1 and the core is held down (neither ready nor waking). Otherwise 2 means the kill level is 1. Otherwise the code is 0.
- R8: Word 0 bit 27 equals the kill pin two edges after the pin changes. Word 2 bit 7 and `kill_irq` become 1 one edge later, for either direction of change. Writing 1 to word 2 bit 7 clears the bit, but a change seen at the same edge wins.
- R9: Writing 1 to word 1 bit 7 makes that bit and `soft_rst_pulse` read 1 for exactly one cycle.
- R10: Word 1 bit 9 (stop master) is host-written and drives `bus_master_stop`. Word 1 bit 8 (master disabled) copies bit 9 one edge later.
- R11: Writes to read-only bits of word 0 (0, 4, 24 to 27), to word 3 and to unlisted bits have no effect. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of the addressed word |
| core_sleep_req | input | 1 | Core asks to enter power-down |
| kill_pin | input | 1 | Asynchronous radio-kill switch level |
| access_ok | output | 1 | Internal resources may be accessed |
| kill_irq | output | 1 | Kill-change cause pending |
| soft_rst_pulse | output | 1 | One-cycle soft-reset strobe |
| bus_master_stop | output | 1 | Request to stop bus mastering |

## Verification
On every cycle, the assertions check the ordering rules of the handshake. Ready never rises without enable, and it falls only after a warning window or a dropped enable. The warning never starts while a request is pending. Soft reset always clears itself, the master-disabled bit always trails the stop bit, and the cause bit rises only after a synchronized level change. The exact wake and sleep latencies, the power-save code priority, the clear-versus-set race on the cause bit and the ignored writes to read-only bits can only be shown by the bench. The bench compares every output and the addressed word against its reference model, and it adds timed directed reads.

// File: rtl/wac_pkg.sv
package wac_pkg;

   typedef enum logic [1:0] {
      PS_OFF      = 2'd0,
      PS_WAKING   = 2'd1,
      PS_AWAKE    = 2'd2,
      PS_SLEEPING = 2'd3
   } pwr_state_e;

   // word indices
   localparam int unsigned ADR_CTL   = 0;
   localparam int unsigned ADR_RST   = 1;
   localparam int unsigned ADR_CAUSE = 2;

   // power-control word fields
   localparam int unsigned CTL_READY = 0;
   localparam int unsigned CTL_EN    = 2;
   localparam int unsigned CTL_REQ   = 3;
   localparam int unsigned CTL_GTS   = 4;
   localparam int unsigned CTL_PS_LO = 24;
   localparam int unsigned CTL_KILL  = 27;

   // reset-control word fields
   localparam int unsigned RST_SOFT  = 7;
   localparam int unsigned RST_MDIS  = 8;
   localparam int unsigned RST_STOP  = 9;

   // cause word field
   localparam int unsigned CAUSE_KILL = 7;

   // power-save codes
   localparam logic [2:0] PSC_NONE  = 3'b000;
   localparam logic [2:0] PSC_CORE  = 3'b001;
   localparam logic [2:0] PSC_RADIO = 3'b010;
   localparam logic [2:0] PSC_ERR   = 3'b011;

   localparam int unsigned MIN_DATA_W = CTL_KILL + 1;

endpackage

// File: rtl/wac_pwr_seq.sv
module wac_pwr_seq
   import wac_pkg::*;
#(
   parameter int unsigned WAKE_CYC  = 8,
   parameter int unsigned SLEEP_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic req_i,
   input  logic sleep_req_i,
   output logic ready_o,
   output logic going_sleep_o,
   output logic held_down_o
);

   localparam int unsigned MAX_CYC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
   localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYC - 1);

   generate
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("wac_pwr_seq: WAKE_CYC must be at least 1");
      end
      if (SLEEP_CYC < 1) begin : g_bad_sleep
         $error("wac_pwr_seq: SLEEP_CYC must be at least 1");
      end
   endgenerate

   pwr_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             wake_cond;
   logic             sleep_cond;

   assign wake_cond  = en_i && (req_i || !sleep_req_i);
   assign sleep_cond = sleep_req_i && !req_i;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         PS_OFF: begin
            if (wake_cond) begin
               state_d = PS_WAKING;
               cnt_d   = '0;
            end
         end
         PS_WAKING: begin
            if (!en_i) begin
               state_d = PS_OFF;
            end else if (cnt_q == WAKE_LAST) begin
               state_d = PS_AWAKE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PS_AWAKE: begin
            if (!en_i) begin
               state_d = PS_OFF;
            end else if (sleep_cond) begin
               state_d = PS_SLEEPING;
               cnt_d   = '0;
            end
         end
         PS_SLEEPING: begin
            if (!en_i || (cnt_q == SLEEP_LAST)) begin
               state_d = PS_OFF;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_OFF;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign ready_o       = (state_q == PS_AWAKE) || (state_q == PS_SLEEPING);
   assign going_sleep_o = (state_q == PS_SLEEPING);
   assign held_down_o   = (state_q == PS_OFF);

endmodule

// File: rtl/wac_pin_sync.sv
module wac_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic prev_o,
   output logic toggle_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wac_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   // STAGES synchronizer flops followed by one history flop
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-1:0], pin_i};
      end
   end

   assign level_o  = chain_q[STAGES-1];
   assign prev_o   = chain_q[STAGES];
   assign toggle_o = level_o ^ prev_o;

endmodule

// File: rtl/wac_reset_ctl.sv
module wac_reset_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic soft_bit_i,
   input  logic stop_bit_i,
   output logic soft_o,
   output logic stop_o,
   output logic mdis_o
);

   logic soft_q, stop_q, mdis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q <= 1'b0;
         stop_q <= 1'b0;
         mdis_q <= 1'b0;
      end else begin
         soft_q <= wr_i && soft_bit_i;
         if (wr_i) begin
            stop_q <= stop_bit_i;
         end
         mdis_q <= stop_q;
      end
   end

   assign soft_o = soft_q;
   assign stop_o = stop_q;
   assign mdis_o = mdis_q;

endmodule

// File: rtl/wake_access_ctl.sv
module wake_access_ctl
   import wac_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned WAKE_CYC    = 8,
   parameter int unsigned SLEEP_CYC   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              core_sleep_req,
   input  logic              kill_pin,
   output logic              access_ok,
   output logic              kill_irq,
   output logic              soft_rst_pulse,
   output logic              bus_master_stop
);

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
         $error("wake_access_ctl: DATA_W too narrow for the control word");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("wake_access_ctl: ADDR_W must be at least 2");
      end
   endgenerate

   // write decode
   logic wr_ctl, wr_rst, wr_cause;
   assign wr_ctl   = reg_wr && (reg_addr == ADDR_W'(ADR_CTL));
   assign wr_rst   = reg_wr && (reg_addr == ADDR_W'(ADR_RST));
   assign wr_cause = reg_wr && (reg_addr == ADDR_W'(ADR_CAUSE));

   // host-owned control bits
   logic en_q, req_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         req_q <= 1'b0;
      end else if (wr_ctl) begin
         en_q  <= reg_wdata[CTL_EN];
         req_q <= reg_wdata[CTL_REQ];
      end
   end

   // power sequencer
   logic ready, gts, held_down;
   wac_pwr_seq #(
      .WAKE_CYC  (WAKE_CYC),
      .SLEEP_CYC (SLEEP_CYC)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (en_q),
      .req_i         (req_q),
      .sleep_req_i   (core_sleep_req),
      .ready_o       (ready),
      .going_sleep_o (gts),
      .held_down_o   (held_down)
   );

   // kill switch synchronizer and change detection
   logic kill_lvl, kill_prev, kill_chg;
   wac_pin_sync #(
      .STAGES (SYNC_STAGES)
   ) u_kill (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (kill_pin),
      .level_o  (kill_lvl),
      .prev_o   (kill_prev),
      .toggle_o (kill_chg)
   );

   // cause bit: write-one-to-clear, a new change wins
   logic cause_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= 1'b0;
      end else if (kill_chg) begin
         cause_q <= 1'b1;
      end else if (wr_cause && reg_wdata[CAUSE_KILL]) begin
         cause_q <= 1'b0;
      end
   end

   // soft reset and bus-master stop
   logic soft_q, stop_q, mdis_q;
   wac_reset_ctl u_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_rst),
      .soft_bit_i (reg_wdata[RST_SOFT]),
      .stop_bit_i (reg_wdata[RST_STOP]),
      .soft_o     (soft_q),
      .stop_o     (stop_q),
      .mdis_o     (mdis_q)
   );

   // power-save code, highest priority first
   logic [2:0] ps_code;
   always_comb begin
      if (!en_q && core_sleep_req) begin
         ps_code = PSC_ERR;
      end else if (en_q && held_down) begin
         ps_code = PSC_CORE;
      end else if (kill_lvl) begin
         ps_code = PSC_RADIO;
      end else begin
         ps_code = PSC_NONE;
      end
   end

   // read words
   logic [DATA_W-1:0] ctl_word, rst_word, cause_word;
   always_comb begin
      ctl_word                          = '0;
      ctl_word[CTL_READY]               = ready;
      ctl_word[CTL_EN]                  = en_q;
      ctl_word[CTL_REQ]                 = req_q;
      ctl_word[CTL_GTS]                 = gts;
      ctl_word[CTL_PS_LO+2:CTL_PS_LO]   = ps_code;
      ctl_word[CTL_KILL]                = kill_lvl;
      rst_word                          = '0;
      rst_word[RST_SOFT]                = soft_q;
      rst_word[RST_MDIS]                = mdis_q;
      rst_word[RST_STOP]                = stop_q;
      cause_word                        = '0;
      cause_word[CAUSE_KILL]            = cause_q;
   end

   always_comb begin
      unique case (reg_addr)
         ADDR_W'(ADR_CTL):   reg_rdata = ctl_word;
         ADDR_W'(ADR_RST):   reg_rdata = rst_word;
         ADDR_W'(ADR_CAUSE): reg_rdata = cause_word;
         default:            reg_rdata = '0;
      endcase
   end

   assign access_ok       = ready && !gts;
   assign kill_irq        = cause_q;
   assign soft_rst_pulse  = soft_q;
   assign bus_master_stop = stop_q;

endmodule

// File: rtl/wac_chk.sv
module wac_chk (
   input logic clk,
   input logic rst_n,
   input logic en_q,
   input logic req_q,
   input logic ready,
   input logic gts,
   input logic access_ok,
   input logic soft_q,
   input logic wr_rst_soft,
   input logic stop_q,
   input logic mdis_q,
   input logic cause_q,
   input logic kill_lvl,
   input logic kill_prev
);

   AST_NO_READY_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !ready);  // R1

   AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> en_q);  // R2

   AST_ACCESS_NOT_IN_WARNING: assert property (@(posedge clk) disable iff (!rst_n)
      access_ok |-> (ready && !gts));  // R3

   AST_WARNING_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      gts |-> ready);  // R4

   AST_FALL_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> ($past(gts) || !$past(en_q)));  // R6

   AST_NO_SLEEP_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gts) |-> !$past(req_q));  // R5

   AST_CAUSE_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q) |-> $past(kill_lvl != kill_prev));  // R8

   AST_SOFT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_q && !wr_rst_soft) |=> !soft_q);  // R9

   AST_MDIS_TRAILS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mdis_q == $past(stop_q)));  // R10

endmodule

bind wake_access_ctl wac_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_q        (en_q),
   .req_q       (req_q),
   .ready       (ready),
   .gts         (gts),
   .access_ok   (access_ok),
   .soft_q      (soft_q),
   .wr_rst_soft (wr_rst && reg_wdata[7]),
   .stop_q      (stop_q),
   .mdis_q      (mdis_q),
   .cause_q     (cause_q),
   .kill_lvl    (kill_lvl),
   .kill_prev   (kill_prev)
);

// File: tb/wake_access_ctl_tb_top.sv
module wake_access_ctl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WAKE  = 5;
   localparam int SLEEP = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        core_sleep_req = 1'b0;
   logic        kill_pin = 1'b0;
   logic        access_ok, kill_irq, soft_rst_pulse, bus_master_stop;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wake_access_ctl #(
      .DATA_W(32), .ADDR_W(2), .WAKE_CYC(WAKE), .SLEEP_CYC(SLEEP), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .core_sleep_req(core_sleep_req), .kill_pin(kill_pin),
      .access_ok(access_ok), .kill_irq(kill_irq),
      .soft_rst_pulse(soft_rst_pulse), .bus_master_stop(bus_master_stop)
   );

   // ---------------- reference model ----------------
   int m_st = 0;   // 0 down, 1 waking, 2 up, 3 warning
   int m_cnt = 0;
   bit m_en = 0, m_req = 0, m_soft = 0, m_stop = 0, m_mdis = 0, m_cause = 0;
   bit kq[$] = '{0, 0, 0};

   function automatic logic [31:0] exp_word(input int a);
      logic [31:0] w;
      int ps;
      w = '0;
      if (a == 0) begin
         if (!m_en && core_sleep_req) ps = 3;
         else if (m_en && m_st == 0) ps = 1;
         else if (kq[1]) ps = 2;
         else ps = 0;
         w[0] = (m_st >= 2);
         w[2] = m_en;
         w[3] = m_req;
         w[4] = (m_st == 3);
         w[26:24] = ps[2:0];
         w[27] = kq[1];
      end else if (a == 1) begin
         w[7] = m_soft; w[8] = m_mdis; w[9] = m_stop;
      end else if (a == 2) begin
         w[7] = m_cause;
      end
      return w;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_en = 0; m_req = 0; m_soft = 0;
         m_stop = 0; m_mdis = 0; m_cause = 0; kq = '{0, 0, 0};
      end else begin
         bit chg;
         case (m_st)
            0: if (m_en && (m_req || !core_sleep_req)) begin m_st = 1; m_cnt = 0; end
            1: if (!m_en) m_st = 0;
               else if (m_cnt == WAKE - 1) m_st = 2;
               else m_cnt++;
            2: if (!m_en) m_st = 0;
               else if (core_sleep_req && !m_req) begin m_st = 3; m_cnt = 0; end
            default: if (!m_en || m_cnt == SLEEP - 1) m_st = 0;
               else m_cnt++;
         endcase
         chg = kq[1] ^ kq[2];
         kq.push_front(kill_pin);
         void'(kq.pop_back());
         if (reg_wr && reg_addr == 2 && reg_wdata[7]) m_cause = 0;
         if (chg) m_cause = 1;
         m_mdis = m_stop;
         m_soft = reg_wr && reg_addr == 1 && reg_wdata[7];
         if (reg_wr && reg_addr == 1) m_stop = reg_wdata[9];
         if (reg_wr && reg_addr == 0) begin m_en = reg_wdata[2]; m_req = reg_wdata[3]; end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // every-cycle comparison, late in the cycle
   always @(posedge clk) begin
      #(CLK_PERIOD/2 - 1);
      if (rst_n && !done) begin
         chk("R3 access_ok", {31'd0, access_ok}, {31'd0, m_st == 2});
         chk("R8 kill_irq", {31'd0, kill_irq}, {31'd0, m_cause});
         chk("R9 soft pulse", {31'd0, soft_rst_pulse}, {31'd0, m_soft});
         chk("R10 bus stop", {31'd0, bus_master_stop}, {31'd0, m_stop});
         case (reg_addr)
            2'd0: chk("R4 word0", reg_rdata, exp_word(0));
            2'd1: chk("R10 word1", reg_rdata, exp_word(1));
            2'd2: chk("R8 word2", reg_rdata, exp_word(2));
            default: chk("R11 word3", reg_rdata, exp_word(3));
         endcase
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a[1:0]; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = a[1:0];
      #1;
      d = reg_rdata;
   endtask

   task automatic edge1();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      edge1(); edge1();
      rd(0, d); chk("R1 reset word0", d, 32'h0);
      rd(1, d); chk("R1 reset word1", d, 32'h0);
      rd(2, d); chk("R1 reset word2", d, 32'h0);

      // request alone never wakes
      wr(0, 32'h8);
      repeat (12) edge1();
      rd(0, d); chk("R1 ready without enable", {31'd0, d[0]}, 32'd0);

      // wake latency
      wr(0, 32'hC);
      repeat (WAKE) edge1();
      rd(0, d); chk("R2 not yet ready", {31'd0, d[0]}, 32'd0);
      edge1();
      rd(0, d); chk("R2 ready", {31'd0, d[0]}, 32'd1);

      // request held: no sleep
      @(negedge clk); core_sleep_req = 1'b1;
      repeat (10) edge1();
      rd(0, d); chk("R5 stays awake", {30'd0, d[4], d[0]}, 32'd1);

      // drop request: sleep entry
      wr(0, 32'h4);
      edge1();
      rd(0, d); chk("R4 warning starts", {30'd0, d[4], d[0]}, 32'd3);
      repeat (SLEEP - 1) edge1();
      rd(0, d); chk("R4 warning held", {30'd0, d[4], d[0]}, 32'd3);
      edge1();
      rd(0, d); chk("R4 powered down", {30'd0, d[4], d[0]}, 32'd0);
      chk("R7 core code", {29'd0, d[26:24]}, 32'd1);

      // request wakes a sleeping core
      wr(0, 32'hC);
      repeat (WAKE) edge1();
      rd(0, d); chk("R5 not yet ready", {31'd0, d[0]}, 32'd0);
      edge1();
      rd(0, d); chk("R5 woken", {31'd0, d[0]}, 32'd1);

      // kill switch rising
      @(negedge clk); kill_pin = 1'b1;
      edge1();
      rd(0, d); chk("R8 level after one edge", {31'd0, d[27]}, 32'd0);
      edge1();
      rd(0, d); chk("R8 level after two edges", {31'd0, d[27]}, 32'd1);
      chk("R7 radio code", {29'd0, d[26:24]}, 32'd2);
      rd(2, d); chk("R8 cause not yet", d, 32'h0);
      edge1();
      rd(2, d); chk("R8 cause set", d, 32'h80);
      wr(2, 32'h80);
      rd(2, d); chk("R8 cause cleared", d, 32'h0);

      // kill switch falling, then clear colliding with a new change
      @(negedge clk); kill_pin = 1'b0;
      repeat (4) edge1();
      rd(2, d); chk("R8 cause on fall", d, 32'h80);
      @(negedge clk); kill_pin = 1'b1;
      @(posedge clk); @(posedge clk);
      wr(2, 32'h80);
      rd(2, d); chk("R8 set wins over clear", d, 32'h80);
      wr(2, 32'h80);
      rd(2, d); chk("R8 cleared after race", d, 32'h0);
      @(negedge clk); kill_pin = 1'b0;
      repeat (4) edge1();
      wr(2, 32'h80);

      // drop enable
      wr(0, 32'h0);
      edge1();
      rd(0, d); chk("R6 ready drops", {30'd0, d[4], d[0]}, 32'd0);
      chk("R7 error code", {29'd0, d[26:24]}, 32'd3);

      // soft reset strobe
      wr(1, 32'h80);
      rd(1, d); chk("R9 soft set", {31'd0, d[7]}, 32'd1);
      edge1();
      rd(1, d); chk("R9 soft cleared", {31'd0, d[7]}, 32'd0);

      // stop master handshake
      wr(1, 32'h200);
      rd(1, d); chk("R10 stop set, disabled pending", d, 32'h200);
      edge1();
      rd(1, d); chk("R10 disabled follows", d, 32'h300);
      wr(1, 32'h0);
      edge1();
      rd(1, d); chk("R10 released", d, 32'h0);

      // read-only bits and unmapped word
      @(negedge clk); core_sleep_req = 1'b0;
      wr(0, 32'hFFFF_FFF3);
      rd(0, d); chk("R11 read-only bits untouched", d, 32'h0);
      wr(3, 32'hFFFF_FFFF);
      rd(3, d); chk("R11 word3 zero", d, 32'h0);
      rd(1, d); chk("R11 word1 untouched", d, 32'h0);
      repeat (5) edge1();
      finish_run();
   end

endmodule